// File: doc/BRIEF.md
# Programmable Repeating Pattern Generator

This block turns an eight-bit pattern word into an endless serial waveform. A free-running step counter walks the select lines of an eight-way selector, one step per clock. Each pattern bit is therefore driven onto a single output for exactly one clock period, and the whole sequence repeats every eight clocks. The frequency and duty cycle of the waveform are set entirely by the pattern, with no divider ratio involved. Symmetric square waves at several rates and arbitrary asymmetric shapes all cost the same logic.

The pattern input is captured into a holding register only during reset and at the moment the counter wraps from its last step back to zero. A pattern change therefore never splices two patterns into one cycle. The output is registered, so the waveform lags the step count by one clock. The current step count is also brought out, so that neighbouring logic can align to the sequence. Both the pattern and the waveform are plain levels. The waveform runs continuously and a consumer cannot stall it, so there is no valid/ready handshake and no back-pressure path.

Top module: `wavepat_gen`

## Requirements
- R1: A synchronous active-high reset sets the step count to 0 and the waveform output to 0 at the next clock edge, and loads the pattern input into the holding register.
- R2: Outside reset, the step count rises by one on every clock edge and wraps from 7 to 0.
- R3: After each non-reset clock edge, the waveform equals bit k of the held pattern, where k is the step count just before that edge. Bit 0 is emitted first in each cycle and bit 7 last.
- R4: Pattern 8'h0F (bits 3..0 high) gives a symmetric square wave with a period of eight clocks: four clocks high, then four low.
- R5: Pattern 8'h33 gives a symmetric wave with a period of four clocks, and pattern 8'h55 gives one with a period of two clocks.
- R6: Asymmetric patterns are reproduced exactly. For example, 8'h01 gives one high clock in every eight.
- R7: The pattern input is sampled only during reset and on the edge where the step count goes from 7 to 0. A change at any other step has no effect on the waveform until the next cycle begins.
- R8: A pattern of all zeros gives a constant low output, and a pattern of all ones gives a constant high output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pattern_in | input | 8 | Pattern word; bit k is emitted at step k |
| wave | output | 1 | Registered serial waveform |
| count | output | 3 | Current step count, 0 to 7 |

## Verification
The square-wave patterns 8'h0F, 8'h33 and 8'h55 are told apart by counting rising edges and high clocks over two full cycles. This shows that the rate follows the pattern rather than a divider. The one-hot pattern 8'h01 exposes a reversed bit order or an off-by-one select, because its single high clock must fall right after step 0. The constant patterns 8'h00 and 8'hFF catch any stray toggling. A pattern switched from 8'h0F to 8'hA5 at step 3 separates capture at the wrap from immediate sampling, because the two words differ at bit 3.

// File: rtl/wavepat_pkg.sv
package wavepat_pkg;
  // Default number of steps in one pattern cycle.
  localparam int unsigned WP_STEPS = 8;
  // Width of the step counter for the default step count.
  localparam int unsigned WP_CNT_W = $clog2(WP_STEPS);
endpackage

// File: rtl/wavepat_step_ctr.sv
module wavepat_step_ctr #(
  parameter int unsigned STEPS = wavepat_pkg::WP_STEPS,
  localparam int unsigned CNT_W = $clog2(STEPS)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] step,
  output logic             at_last
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  assign at_last = (step == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= '0;
    end else if (at_last) begin
      step <= '0;
    end else begin
      step <= step + CNT_W'(1);
    end
  end
endmodule

// File: rtl/wavepat_hold.sv
module wavepat_hold #(
  parameter int unsigned STEPS = wavepat_pkg::WP_STEPS
) (
  input  logic             clk,
  input  logic             load,
  input  logic [STEPS-1:0] pat_d,
  output logic [STEPS-1:0] pat_q
);
  // Holding register: the pattern is updated only at a cycle boundary.
  always_ff @(posedge clk) begin
    if (load) begin
      pat_q <= pat_d;
    end
  end
endmodule

// File: rtl/wavepat_sel.sv
module wavepat_sel #(
  parameter int unsigned STEPS = wavepat_pkg::WP_STEPS,
  localparam int unsigned CNT_W = $clog2(STEPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] sel,
  input  logic [STEPS-1:0] pat,
  output logic             q
);
  logic [STEPS-1:0] hit;
  logic             pick;

  // Decoded AND-OR selector: one term per pattern bit.
  for (genvar g = 0; g < STEPS; g++) begin : g_term
    assign hit[g] = (sel == CNT_W'(g)) & pat[g];
  end

  assign pick = |hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else begin
      q <= pick;
    end
  end
endmodule

// File: rtl/wavepat_gen.sv
module wavepat_gen #(
  parameter int unsigned STEPS = wavepat_pkg::WP_STEPS,
  localparam int unsigned CNT_W = $clog2(STEPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [STEPS-1:0] pattern_in,
  output logic             wave,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] step;
  logic             at_last;
  logic [STEPS-1:0] pat_active;

  wavepat_step_ctr #(.STEPS(STEPS)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .at_last (at_last)
  );

  wavepat_hold #(.STEPS(STEPS)) u_hold (
    .clk   (clk),
    .load  (rst | at_last),
    .pat_d (pattern_in),
    .pat_q (pat_active)
  );

  wavepat_sel #(.STEPS(STEPS)) u_sel (
    .clk (clk),
    .rst (rst),
    .sel (step),
    .pat (pat_active),
    .q   (wave)
  );

  assign count = step;
endmodule

// File: rtl/wavepat_gen_chk.sv
module wavepat_gen_chk #(
  parameter int unsigned STEPS = wavepat_pkg::WP_STEPS,
  localparam int unsigned CNT_W = $clog2(STEPS)
) (
  input logic             clk,
  input logic             rst,
  input logic [STEPS-1:0] pattern_in,
  input logic [STEPS-1:0] pat_active,
  input logic             wave,
  input logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (count == '0) && (wave == 1'b0));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> count == (($past(count) == LAST) ? '0 : $past(count) + CNT_W'(1)));

  assert_wave_source_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> wave == $past(pat_active[count]));

  assert_pattern_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && count != '0) |-> $stable(pat_active));

  assert_pattern_load_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && count == '0) |-> pat_active == $past(pattern_in));
endmodule

bind wavepat_gen wavepat_gen_chk #(.STEPS(STEPS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pattern_in (pattern_in),
  .pat_active (pat_active),
  .wave       (wave),
  .count      (count)
);

// File: tb/wavepat_gen_tb.sv
module wavepat_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pattern_in = 8'h0F;
  logic       wave;
  logic [2:0] count;

  int total = 0;
  int bad = 0;

  // Reference state built from the requirements.
  int   m_cnt = 0;
  logic [7:0] m_pat = 8'h00;
  logic m_wave = 1'b0;

  int rises;
  int highs;
  logic prev_w;

  always #10 clk = ~clk;

  wavepat_gen u_dut (
    .clk        (clk),
    .rst        (rst),
    .pattern_in (pattern_in),
    .wave       (wave),
    .count      (count)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_cnt  <= 0;
      m_pat  <= pattern_in;
      m_wave <= 1'b0;
    end else begin
      m_wave <= m_pat[m_cnt];
      m_cnt  <= (m_cnt + 1) % 8;
      if (m_cnt == 7) m_pat <= pattern_in;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock, then compare count (R2) and wave (R3) against the reference.
  task automatic step1();
    @(negedge clk);
    chk(int'(count) == m_cnt, "R2 count", int'(count), m_cnt);
    chk(wave == m_wave, "R3 wave", int'(wave), int'(m_wave));
    if (wave && !prev_w) rises++;
    if (wave) highs++;
    prev_w = wave;
  endtask

  task automatic t_reset(input logic [7:0] p);
    @(negedge clk);
    rst = 1'b1;
    pattern_in = p;
    @(negedge clk);
    @(negedge clk);
    chk(count == 3'd0, "R1 count", int'(count), 0);
    chk(wave == 1'b0, "R1 wave", int'(wave), 0);
    rst = 1'b0;
    rises = 0;
    highs = 0;
    prev_w = 1'b0;
  endtask

  task automatic t_pattern(input logic [7:0] p, input int exp_r, input int exp_h, input string req);
    t_reset(p);
    for (int i = 0; i < 16; i++) step1();
    chk(rises == exp_r, {req, " rising edges"}, rises, exp_r);
    chk(highs == exp_h, {req, " high clocks"}, highs, exp_h);
  endtask

  // R7: change the pattern at step 3; the current cycle must finish on the old word.
  task automatic t_midchange();
    t_reset(8'h0F);
    for (int i = 0; i < 3; i++) step1();
    chk(int'(count) == 3, "R7 setup count", int'(count), 3);
    pattern_in = 8'hA5;
    step1();
    chk(wave == 1'b1, "R7 old bit3 kept", int'(wave), 1);
    for (int i = 0; i < 4; i++) step1();
    chk(int'(count) == 0, "R7 wrap count", int'(count), 0);
    chk(wave == 1'b0, "R7 old bit7 kept", int'(wave), 0);
    step1();
    chk(wave == 1'b1, "R7 new bit0", int'(wave), 1);
    for (int i = 0; i < 3; i++) step1();
    chk(wave == 1'b0, "R7 new bit3", int'(wave), 0);
    for (int i = 0; i < 8; i++) step1();
  endtask

  // R1: reset in the middle of a cycle restarts the sequence at step 0.
  task automatic t_midreset();
    t_reset(8'h33);
    for (int i = 0; i < 5; i++) step1();
    t_reset(8'h01);
    step1();
    chk(int'(count) == 1, "R1 restart count", int'(count), 1);
    chk(wave == 1'b1, "R1 restart bit0", int'(wave), 1);
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rises = 0;
    highs = 0;
    prev_w = 1'b0;
    t_pattern(8'h0F, 2, 8, "R4");
    t_pattern(8'h33, 4, 8, "R5 8'h33");
    t_pattern(8'h55, 8, 8, "R5 8'h55");
    t_pattern(8'h01, 2, 2, "R6");
    t_pattern(8'h00, 0, 0, "R8 zeros");
    t_pattern(8'hFF, 1, 16, "R8 ones");
    t_midchange();
    t_midreset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule